// File: doc/BRIEF.md
# Strobe-Gated One-of-Eight Decoder

This block turns a 3-bit select code into eight active-high lines, of which at most one is high. A line is high only inside a window opened and closed by two bus timing strobes. The first strobe's falling edge opens the window and the second strobe's falling edge closes it. The block keeps this window in an internal enable flag. A chip-enable input blanks the whole block. Because of that, a decoded line of one instance can drive the chip enable of another, which builds a multi-level port-select tree.

Both strobes are treated as synchronous inputs. A falling edge is a sample of 1 followed by a sample of 0 on consecutive clocks. The flag is a register, and the outputs are registered from the flag, the chip enable and the select code. Reset is synchronous and active low.

Top module: `strobe_decoder`

## Requirements
- R1: With the flag set and chip enable high, output line k (bit k of `line_o`) goes high for select value k, where `sel_i[2]` is the most significant bit. Every other line stays low, and at no time is more than one line high.
- R2: A clock with `ce_i` low clears the flag and drives all of `line_o` low on that edge. The strobes and the select code have no effect while this holds, and the flag stays clear after `ce_i` returns high until a new falling edge of strobe A.
- R3: With `ce_i` high, a falling edge of strobe A sets the flag on the clock that samples the 0. The selected line rises on the following clock.
- R4: A clock that samples strobe A high clears the flag, and every line is low one clock later.
- R5: A falling edge of strobe B clears the flag. When falling edges of A and B are detected on the same clock, the flag is cleared.
- R6: While both strobes sample low with no edge, the flag keeps its value, whether set or clear.
- R7: With strobe B held low, strobe A alone controls the window: its falling edge opens it and its next high sample closes it.
- R8: Synchronous reset (`rst_ni` low) clears the flag, both strobe history bits and `line_o`. A strobe A that was high before reset and is low after it is not taken as a falling edge.
- R9: `line_o` is registered. A change of `sel_i` inside an open window shows on `line_o` after exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| stb_a_i | input | 1 | Opening strobe (first bus timing pulse) |
| stb_b_i | input | 1 | Closing strobe (second bus timing pulse) |
| sel_i | input | 3 | Select code |
| line_o | output | 8 | Decoded lines, active high |

## Verification
The bench counts clocks exactly across a full strobe cycle. A design that decodes combinationally, or that sets the flag one edge late, shows the line a cycle off. Simultaneous falling edges are one target: a design that gives the set priority would leave a line stuck on. The bench also turns chip enable off in mid-window and then back on. A design that only masks the outputs, instead of clearing the flag, would bring the line back. Finally, it resets while strobe A is high and releases reset with A low. A design that keeps the strobe history through reset would see a spurious edge and open a window.

// File: rtl/strobe_decoder.sv
module strobe_decoder #(
  parameter int SEL_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_i,
  input  logic                stb_a_i,
  input  logic                stb_b_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [(1<<SEL_W)-1:0] line_o
);
  localparam int NOUT = 1 << SEL_W;

  logic a_last, b_last, win;
  logic a_fall, b_fall;

  assign a_fall = a_last & ~stb_a_i;
  assign b_fall = b_last & ~stb_b_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_last <= 1'b0;
      b_last <= 1'b0;
    end else begin
      a_last <= stb_a_i;
      b_last <= stb_b_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      win <= 1'b0;
    else if (!ce_i)   win <= 1'b0;
    else if (stb_a_i) win <= 1'b0;
    else if (b_fall)  win <= 1'b0;
    else if (a_fall)  win <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)           line_o <= '0;
    else if (ce_i && win)  line_o <= NOUT'(1) << sel_i;
    else                   line_o <= '0;
  end

  assert_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_o));
  assert_decode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && win) |=> line_o == (NOUT'(1) << $past(sel_i)));
  assert_ce_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (line_o == '0 && !win));
  assert_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && a_fall && !b_fall) |=> win);
  assert_a_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_a_i |=> !win);
  assert_b_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_fall && b_fall) |=> !win);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !stb_a_i && !stb_b_i && !a_last && !b_last) |=> $stable(win));
endmodule

// File: tb/test_strobe_decoder.sv
module test_strobe_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, sa = 1'b0, sb = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] line;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strobe_decoder i_strobe_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .stb_a_i(sa), .stb_b_i(sb),
    .sel_i(sel), .line_o(line)
  );

  task automatic cyc(input logic a, input logic b);
    sa = a; sb = b;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (line !== exp) begin
      fails++;
      $display("FAIL %s: line=%b expected=%b", req, line, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce = 1'b1; sa = 1'b0; sb = 1'b0; sel = '0;
    @(negedge clk); @(negedge clk);
    chk("R8 reset", 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic t_full_cycle(input logic [2:0] s);
    sel = s; ce = 1'b1;
    cyc(1, 0); chk("R4 A high", 8'h00);
    cyc(0, 0); chk("R3 flag only", 8'h00);
    cyc(0, 1); chk("R1 R3 active", 8'h01 << s);
    cyc(0, 0); chk("R5 B fall edge", 8'h01 << s);
    cyc(0, 0); chk("R5 closed", 8'h00);
  endtask

  task automatic t_all_codes();
    for (int k = 0; k < 8; k++) t_full_cycle(3'(k));
  endtask

  task automatic t_hold();
    sel = 3'd5;
    cyc(0, 0); cyc(0, 0); chk("R6 hold clear", 8'h00);
    cyc(1, 0); cyc(0, 0); cyc(0, 0);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0); chk("R6 hold set", 8'h20);
    end
    cyc(0, 1); chk("R6 B high holds", 8'h20);
    cyc(0, 0); cyc(0, 0); chk("R5 close", 8'h00);
  endtask

  task automatic t_ce_low();
    sel = 3'd2;
    cyc(1, 0); cyc(0, 0); cyc(0, 0); chk("R3 open", 8'h04);
    ce = 1'b0; cyc(0, 0); chk("R2 ce low blank", 8'h00);
    sel = 3'd6; cyc(1, 0); cyc(0, 0); chk("R2 ignore strobes", 8'h00);
    ce = 1'b1; cyc(0, 0); cyc(0, 0); chk("R2 flag stays clear", 8'h00);
  endtask

  task automatic t_sel_change();
    sel = 3'd1;
    cyc(1, 0); cyc(0, 0); cyc(0, 0); chk("R9 open", 8'h02);
    sel = 3'd7; cyc(0, 0); chk("R9 one clock", 8'h80);
    sel = 3'd4; cyc(0, 0); chk("R9 one clock", 8'h10);
    cyc(1, 0); cyc(0, 0); chk("R4 A high closes", 8'h00);
  endtask

  task automatic t_both_fall();
    sel = 3'd3;
    cyc(1, 1); cyc(0, 0); cyc(0, 0); chk("R5 B priority", 8'h00);
    cyc(0, 0); chk("R5 B priority held", 8'h00);
  endtask

  task automatic t_b_tied();
    sel = 3'd6;
    cyc(1, 0); chk("R7 idle", 8'h00);
    cyc(0, 0); cyc(0, 0); chk("R7 A opens", 8'h40);
    cyc(0, 0); chk("R7 stays", 8'h40);
    cyc(1, 0); cyc(0, 0); chk("R7 A closes", 8'h00);
  endtask

  task automatic t_reset_history();
    sel = 3'd0;
    cyc(1, 0);
    rst_n = 1'b0; @(negedge clk); chk("R8 in reset", 8'h00);
    rst_n = 1'b1; sa = 1'b0;
    cyc(0, 0); cyc(0, 0); chk("R8 no false edge", 8'h00);
    cyc(1, 0); cyc(0, 0);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    cyc(0, 0); chk("R8 flag cleared", 8'h00);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_all_codes();
    t_hold();
    t_ce_low();
    t_sel_change();
    t_both_fall();
    t_b_tied();
    t_reset_history();
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 5000 && !done; k++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: line=%b expected=completion", line);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule